// File: doc/BRIEF.md
# I2C Control-Register Slave with High-Speed Mode Tracking

This block is the two-wire slave front end for the control registers of a data converter. It samples SCL and SDA with the faster system clock and finds START, repeated START and STOP on the bus. It compares the first byte of each transfer with a fixed 7-bit device address and acknowledges a match by enabling an open-drain pull-down on SDA.

On a write, each data byte that follows is acknowledged. The byte's top bit sends it to one of two registers: the setup register or the configuration register. Every load raises a one-cycle strobe. A read address is acknowledged and raises a one-cycle request pulse, and another block supplies the read data.

The block also keeps track of the bus speed mode. A high-speed master code after a START is answered with a not-acknowledge and sets the high-speed flag. The flag stays set across repeated STARTs and is cleared by a STOP.

Top module: `i2c_cfg_slave`

## Requirements
- R1: After reset, sda_oe, hs_mode, all strobes and both register outputs are 0.
- R2: When the first byte after a START carries the device address (default 7'b1101101) in bits 7..1 and a 0 (write) in bit 0, the block holds SDA low for the whole high period of the ninth SCL pulse.
- R3: A first byte that is neither the device address nor a high-speed master code is not acknowledged. Later bytes are then neither acknowledged nor loaded until the next START or STOP.
- R4: In a write, a data byte with bit 7 = 1 is acknowledged and loaded into setup_q. setup_we is high for one cycle after the ninth SCL falling edge, and in that same cycle sda_oe is released.
- R5: In a write, a data byte with bit 7 = 0 is acknowledged and loaded into config_q, with a one-cycle config_we pulse.
- R6: Data bytes may arrive in any order and in any number. Each one is routed by its bit 7, so the last byte sent to a register is the value it keeps. The two strobes never fire together.
- R7: A first byte matching 8'b00001xxx after a START is not acknowledged (SDA released on the ninth clock), and hs_mode is then set.
- R8: A repeated START leaves hs_mode unchanged, and addressed writes keep working in high-speed mode.
- R9: A STOP clears hs_mode.
- R10: The device address with bit 0 = 1 (read) is acknowledged and raises rd_req for exactly one cycle, and no register is loaded.
- R11: sda_oe changes only while the synchronized SCL is low.
- R12: A START or STOP in the middle of a byte discards the partial byte without loading any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | Pull SDA low when 1 |
| setup_q | output | 8 | Setup register contents |
| setup_we | output | 1 | One-cycle pulse on setup register load |
| config_q | output | 8 | Configuration register contents |
| config_we | output | 1 | One-cycle pulse on configuration register load |
| hs_mode | output | 1 | High-speed mode flag |
| rd_req | output | 1 | One-cycle pulse on an acknowledged read address |

## Verification
Two things share one system-clock cycle: the register load with its strobe, and the release of the acknowledge at the ninth SCL falling edge. The same edge both sets hs_mode and ends the not-acknowledge of the master code. Back-to-back data bytes of both kinds provoke this. The scoreboard monitor judges each strobe against its queued value and checks that sda_oe is already low in that cycle. The high-speed entry is judged by the not-acknowledge seen on the line and by hs_mode being set, with no strobe, before the repeated START.

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave #(
  parameter logic [6:0] DEV_ADDR = 7'b1101101
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [7:0] setup_q,
  output logic       setup_we,
  output logic [7:0] config_q,
  output logic       config_we,
  output logic       hs_mode,
  output logic       rd_req
);

  typedef enum logic [1:0] {IDLE, ADDR, WDATA, SKIP} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_p, sda_p;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_det, stop_det;
  st_t        st;
  logic [3:0] cnt;
  logic       ack_ph;
  logic [7:0] sh;
  logic       rx_st, addr_hit, hs_code;

  assign scl_s     = scl_sy[1];
  assign sda_s     = sda_sy[1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  assign rx_st     = (st == ADDR) || (st == WDATA);
  assign addr_hit  = (sh[7:1] == DEV_ADDR);
  assign hs_code   = (sh[7:3] == 5'b00001);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= IDLE;
      cnt       <= '0;
      ack_ph    <= 1'b0;
      sh        <= '0;
      sda_oe    <= 1'b0;
      setup_q   <= '0;
      config_q  <= '0;
      setup_we  <= 1'b0;
      config_we <= 1'b0;
      hs_mode   <= 1'b0;
      rd_req    <= 1'b0;
    end else begin
      setup_we  <= 1'b0;
      config_we <= 1'b0;
      rd_req    <= 1'b0;
      if (stop_det) begin
        st      <= IDLE;
        ack_ph  <= 1'b0;
        sda_oe  <= 1'b0;
        hs_mode <= 1'b0;
      end else if (start_det) begin
        st     <= ADDR;
        cnt    <= '0;
        ack_ph <= 1'b0;
        sda_oe <= 1'b0;
      end else if (rx_st && scl_rise && !ack_ph && cnt < 4'd8) begin
        sh  <= {sh[6:0], sda_s};
        cnt <= cnt + 4'd1;
      end else if (rx_st && scl_fall && !ack_ph && cnt == 4'd8) begin
        ack_ph <= 1'b1;
        sda_oe <= (st == WDATA) || addr_hit;
      end else if (rx_st && scl_fall && ack_ph) begin
        ack_ph <= 1'b0;
        cnt    <= '0;
        sda_oe <= 1'b0;
        if (st == ADDR) begin
          if (addr_hit) begin
            st     <= sh[0] ? SKIP : WDATA;
            rd_req <= sh[0];
          end else begin
            st <= SKIP;
            if (hs_code) hs_mode <= 1'b1;
          end
        end else if (sh[7]) begin
          setup_q  <= sh;
          setup_we <= 1'b1;
        end else begin
          config_q  <= sh;
          config_we <= 1'b1;
        end
      end
    end
  end

  // R11
  sda_oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);
  // R4
  setup_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_we |-> (setup_q[7] && !sda_oe));
  // R5
  config_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    config_we |-> (!config_q[7] && !sda_oe));
  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(setup_we && config_we));
  // R7
  hs_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_mode) |-> (!sda_oe && !scl_s));
  // R9
  stop_clears_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !hs_mode);
  // R10
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

endmodule

// File: tb/i2c_cfg_slave_test.sv
module i2c_cfg_slave_test;
  localparam int Q = 10;
  localparam logic [6:0] ADR = 7'b1101101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, setup_we, config_we, hs_mode, rd_req;
  logic [7:0] setup_q, config_q;
  logic sda_line;
  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [9:0] expq[$];

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_cfg_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .setup_q(setup_q), .setup_we(setup_we), .config_q(config_q),
    .config_we(config_we), .hs_mode(hs_mode), .rd_req(rd_req));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; w(Q); scl = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; w(Q); scl = 1'b1; w(Q); sda_m = 1'b1; w(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; w(Q); scl = 1'b1; w(2*Q); scl = 1'b0; w(Q);
    end
    sda_m = 1'b1; w(Q); scl = 1'b1; w(Q);
    ack = !sda_line;
    w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic push(input logic [1:0] kind, input logic [7:0] v);
    expq.push_back({kind, v});
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (setup_we || config_we || rd_req)) begin
      logic [9:0] got, e;
      got = setup_we ? {2'd1, setup_q} : config_we ? {2'd2, config_q} : {2'd3, 8'h00};
      chk(!sda_oe, "R4 ack released with strobe", sda_oe, 0);
      if (expq.size() == 0) begin
        chk(0, "R3/R12 unexpected strobe", got, 0);
      end else begin
        e = expq.pop_front();
        chk(got == e, "R4/R5/R10 scoreboard item", got, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit a;
    w(5);
    @(negedge clk);
    chk(!sda_oe && !hs_mode && setup_q == 0 && config_q == 0, "R1 reset outputs",
        {sda_oe, hs_mode, setup_q, config_q}, 0);
    rst_n = 1'b1;
    w(5);
    @(negedge clk);
    chk(!setup_we && !config_we && !rd_req, "R1 strobes idle", {setup_we, config_we, rd_req}, 0);

    // plain write, setup then config
    bus_start;
    send_byte({ADR, 1'b0}, a); chk(a, "R2 address ack", a, 1);
    push(2'd1, 8'h85);
    send_byte(8'h85, a); chk(a, "R4 setup byte ack", a, 1);
    push(2'd2, 8'h12);
    send_byte(8'h12, a); chk(a, "R5 config byte ack", a, 1);
    bus_stop; w(4);
    chk(setup_q == 8'h85, "R4 setup value", setup_q, 8'h85);
    chk(config_q == 8'h12, "R5 config value", config_q, 8'h12);

    // reversed order, three bytes
    bus_start;
    send_byte({ADR, 1'b0}, a);
    push(2'd2, 8'h33); send_byte(8'h33, a);
    push(2'd1, 8'hC1); send_byte(8'hC1, a);
    push(2'd2, 8'h44); send_byte(8'h44, a); chk(a, "R6 third byte ack", a, 1);
    bus_stop; w(4);
    chk(config_q == 8'h44, "R6 last config wins", config_q, 8'h44);
    chk(setup_q == 8'hC1, "R6 setup value", setup_q, 8'hC1);

    // foreign address
    bus_start;
    send_byte({7'h50, 1'b0}, a); chk(!a, "R3 foreign address nack", a, 0);
    send_byte(8'h99, a); chk(!a, "R3 ignored byte nack", a, 0);
    send_byte(8'h11, a);
    bus_stop; w(4);
    chk(setup_q == 8'hC1 && config_q == 8'h44, "R3 registers untouched",
        {setup_q, config_q}, {8'hC1, 8'h44});

    // read address
    bus_start;
    push(2'd3, 8'h00);
    send_byte({ADR, 1'b1}, a); chk(a, "R10 read address ack", a, 1);
    bus_stop; w(4);
    chk(setup_q == 8'hC1 && config_q == 8'h44, "R10 no register load",
        {setup_q, config_q}, {8'hC1, 8'h44});

    // high-speed entry
    bus_start;
    send_byte(8'h0B, a); chk(!a, "R7 master code nack", a, 0);
    w(4); chk(hs_mode, "R7 hs set", hs_mode, 1);
    bus_start; w(4);
    chk(hs_mode, "R8 hs kept over repeated start", hs_mode, 1);
    send_byte({ADR, 1'b0}, a); chk(a, "R8 address ack in hs", a, 1);
    push(2'd1, 8'h9E); send_byte(8'h9E, a);
    bus_start; w(4);
    chk(hs_mode, "R8 hs kept after write", hs_mode, 1);
    chk(setup_q == 8'h9E, "R8 setup written in hs", setup_q, 8'h9E);
    bus_stop; w(4);
    chk(!hs_mode, "R9 stop clears hs", hs_mode, 0);

    bus_start;
    send_byte(8'h08, a); chk(!a, "R7 master code low bits zero nack", a, 0);
    w(4); chk(hs_mode, "R7 hs set code 08", hs_mode, 1);
    bus_stop; w(4);
    chk(!hs_mode, "R9 stop clears hs again", hs_mode, 0);

    // partial byte aborted by stop
    bus_start;
    send_byte({ADR, 1'b0}, a);
    for (int i = 0; i < 4; i++) begin
      sda_m = 1'b1; w(Q); scl = 1'b1; w(2*Q); scl = 1'b0; w(Q);
    end
    bus_stop; w(4);
    chk(setup_q == 8'h9E, "R12 partial byte discarded", setup_q, 8'h9E);
    bus_start;
    send_byte({ADR, 1'b0}, a); chk(a, "R12 next transfer ack", a, 1);
    push(2'd2, 8'h05); send_byte(8'h05, a);
    bus_stop; w(4);
    chk(config_q == 8'h05, "R12 next transfer loads", config_q, 8'h05);

    w(20);
    chk(expq.size() == 0, "R6 all expected items seen", expq.size(), 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule